// File: doc/BRIEF.md
# Banked Data Address Generator

This block turns the operand field of a byte- or bit-oriented instruction into a 12-bit data-memory address for a small 8-bit core whose register file is split into sixteen 256-byte banks. It holds the bank register and a 12-bit base pointer. Each of them is loaded through a write-enable port. Each decode strobe yields a registered effective address and a 2-bit code naming the addressing mode that was chosen.

The access bit of the instruction word picks the mapping. When it is set, the address is the bank number followed by the 8-bit operand. When it is clear, operands at 60h and above always land in the top bank (F60h..FFFh). Operands below 60h are used in one of two ways. With extended mode on, they are an unsigned offset added to the base pointer. With extended mode off, they map straight to 000h..05Fh.

Top module: `bank_addr_gen`

## Requirements
- R1: With instruction bit 8 (access bit) set, the next registered address is {bank register, instr[7:0]} and the mode code is 0, for every operand value.
- R2: With bit 8 clear and instr[7:0] >= 60h, the address is F00h + instr[7:0] and the mode code is 1, whatever the extended-mode input.
- R3: With bit 8 clear, instr[7:0] <= 5Fh and ext_en high, the address is (pointer + instr[7:0]) mod 4096 and the mode code is 2.
- R4: With bit 8 clear, instr[7:0] <= 5Fh and ext_en low, the address is 000h + instr[7:0] and the mode code is 1.
- R5: Instruction bits 15..9 have no effect on the address or the mode code.
- R6: A cycle with bank_we high loads bank_wd into the bank register. The new value is used by any decode strobed in a later cycle.
- R7: ptr_hi_we loads ptr_wd[3:0] into pointer bits 11..8, and ptr_wd[7:4] are dropped. ptr_lo_we loads ptr_wd into pointer bits 7..0.
- R8: While reset is held, and right after it, the address, the mode code, the bank register and the pointer are all zero.
- R9: While instr_valid is low, eff_addr and addr_mode keep their values.
- R10: The address and mode for a strobed instruction appear on the clock edge that samples instr_valid high, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction word |
| instr_valid | input | 1 | Decode strobe |
| ext_en | input | 1 | Extended (indexed) mode enable |
| bank_we | input | 1 | Bank register write enable |
| bank_wd | input | 4 | Bank register write data |
| ptr_hi_we | input | 1 | Pointer high-half write enable |
| ptr_lo_we | input | 1 | Pointer low-half write enable |
| ptr_wd | input | 8 | Pointer write data |
| eff_addr | output | 12 | Registered effective address |
| addr_mode | output | 2 | Registered mode code: 0 long, 1 forced, 2 indexed |

## Verification
Operands are taken on both sides of the 5Fh/60h boundary with the access bit set and clear, so that a comparison off by one, or a swapped branch, moves an address from one mode to another. Pointer values close to FFFh, combined with large offsets, separate a sum that wraps modulo 4096 from one that is truncated or saturated. Toggling ext_en with the same operand shows whether the extended-mode gating is applied to low operands only. Random bank and pointer writes mixed with random upper instruction bits catch stale register use and any leak from bits 15..9.

// File: rtl/bag_pkg.sv
package bag_pkg;
   typedef enum logic [1:0] {
      MODE_LONG    = 2'd0,
      MODE_FORCED  = 2'd1,
      MODE_INDEXED = 2'd2
   } addr_mode_e;
endpackage

// File: rtl/bag_regs.sv
module bag_regs #(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 12,
   parameter int BANK_W = ADDR_W - BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_we,
   input  logic [BANK_W-1:0] bank_wd,
   input  logic              ptr_hi_we,
   input  logic              ptr_lo_we,
   input  logic [BYTE_W-1:0] ptr_wd,
   output logic [BANK_W-1:0] bank_q,
   output logic [ADDR_W-1:0] ptr_q
);
   localparam int HI_W = ADDR_W - BYTE_W;

   initial begin
      hi_w_chk: assert (HI_W > 0 && HI_W <= BYTE_W)
         else $error("pointer high half must fit one byte");
   end

   logic [BYTE_W-1:0] lo_q;
   logic [HI_W-1:0]   hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else begin
         if (bank_we)   bank_q <= bank_wd;
         if (ptr_lo_we) lo_q   <= ptr_wd;
         if (ptr_hi_we) hi_q   <= ptr_wd[HI_W-1:0];
      end
   end

   assign ptr_q = {hi_q, lo_q};

   generate
      if (HI_W < BYTE_W) begin : g_drop_hi
         logic unused_hi_bits;
         assign unused_hi_bits = ^ptr_wd[BYTE_W-1:HI_W];
      end
   endgenerate

   // R6
   bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |=> bank_q == $past(bank_wd));
   // R7
   ptr_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_hi_we |=> ptr_q[ADDR_W-1:BYTE_W] == $past(ptr_wd[HI_W-1:0]));
endmodule

// File: rtl/bag_decode.sv
module bag_decode
   import bag_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int ADDR_W     = 12,
   parameter int BANK_W     = ADDR_W - BYTE_W,
   parameter int FORCE_BASE = 96,
   parameter bit INDEX_EN   = 1'b1
) (
   input  logic              acc,
   input  logic [BYTE_W-1:0] f,
   input  logic              ext_en,
   input  logic [BANK_W-1:0] bank,
   input  logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] addr,
   output addr_mode_e        mode
);
   localparam logic [BANK_W-1:0] TOP_BANK = {BANK_W{1'b1}};
   localparam logic [BYTE_W-1:0] SPLIT    = BYTE_W'(FORCE_BASE);

   initial begin
      split_chk: assert (FORCE_BASE > 0 && FORCE_BASE < (1 << BYTE_W))
         else $error("force split must lie inside the operand range");
   end

   logic              low_f;
   logic              idx_ok;
   logic [ADDR_W-1:0] idx_addr;

   assign low_f = (f < SPLIT);

   generate
      if (INDEX_EN) begin : g_index
         assign idx_addr = ptr + {{BANK_W{1'b0}}, f};
         assign idx_ok   = ext_en;
      end else begin : g_no_index
         logic unused_idx;
         assign unused_idx = ext_en ^ (^ptr);
         assign idx_addr   = '0;
         assign idx_ok     = 1'b0;
      end
   endgenerate

   always_comb begin
      if (acc) begin
         addr = {bank, f};
         mode = MODE_LONG;
      end else if (!low_f) begin
         addr = {TOP_BANK, f};
         mode = MODE_FORCED;
      end else if (idx_ok) begin
         addr = idx_addr;
         mode = MODE_INDEXED;
      end else begin
         addr = {{BANK_W{1'b0}}, f};
         mode = MODE_FORCED;
      end
   end
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
   import bag_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int BYTE_W     = 8,
   parameter int INSTR_W    = 16,
   parameter int ACC_BIT    = 8,
   parameter int FORCE_BASE = 96,
   parameter bit INDEX_EN   = 1'b1,
   localparam int BANK_W    = ADDR_W - BYTE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] instr,
   input  logic               instr_valid,
   input  logic               ext_en,
   input  logic               bank_we,
   input  logic [BANK_W-1:0]  bank_wd,
   input  logic               ptr_hi_we,
   input  logic               ptr_lo_we,
   input  logic [BYTE_W-1:0]  ptr_wd,
   output logic [ADDR_W-1:0]  eff_addr,
   output logic [1:0]         addr_mode
);
   initial begin
      field_chk: assert (ACC_BIT == BYTE_W && ACC_BIT < INSTR_W - 1)
         else $error("access bit must sit just above the operand byte");
   end

   logic [BANK_W-1:0] bank_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] dec_addr;
   addr_mode_e        dec_mode;
   logic [BYTE_W-1:0] f_fld;
   logic              acc_fld;
   logic              unused_instr;

   assign f_fld        = instr[BYTE_W-1:0];
   assign acc_fld      = instr[ACC_BIT];
   assign unused_instr = ^instr[INSTR_W-1:ACC_BIT+1];

   bag_regs #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .bank_we(bank_we), .bank_wd(bank_wd),
      .ptr_hi_we(ptr_hi_we), .ptr_lo_we(ptr_lo_we), .ptr_wd(ptr_wd),
      .bank_q(bank_q), .ptr_q(ptr_q)
   );

   bag_decode #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
                .FORCE_BASE(FORCE_BASE), .INDEX_EN(INDEX_EN)) dec_i (
      .acc(acc_fld), .f(f_fld), .ext_en(ext_en),
      .bank(bank_q), .ptr(ptr_q),
      .addr(dec_addr), .mode(dec_mode)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eff_addr  <= '0;
         addr_mode <= 2'd0;
      end else if (instr_valid) begin
         eff_addr  <= dec_addr;
         addr_mode <= dec_mode;
      end
   end

   // R1
   long_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && instr[ACC_BIT] |=>
         addr_mode == 2'd0 && eff_addr[BYTE_W-1:0] == $past(instr[BYTE_W-1:0]));
   // R2
   forced_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && !instr[ACC_BIT] && instr[BYTE_W-1:0] >= BYTE_W'(FORCE_BASE) |=>
         addr_mode == 2'd1 && eff_addr == {{BANK_W{1'b1}}, $past(instr[BYTE_W-1:0])});
   // R3
   idx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && !instr[ACC_BIT] && instr[BYTE_W-1:0] < BYTE_W'(FORCE_BASE) && ext_en |=>
         addr_mode == (INDEX_EN ? 2'd2 : 2'd1));
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> $stable(eff_addr) && $stable(addr_mode));
endmodule

// File: tb/bank_addr_gen_tb.sv
`timescale 1ns/1ps
module bank_addr_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr = '0;
   logic        instr_valid = 1'b0;
   logic        ext_en = 1'b0;
   logic        bank_we = 1'b0;
   logic [3:0]  bank_wd = '0;
   logic        ptr_hi_we = 1'b0;
   logic        ptr_lo_we = 1'b0;
   logic [7:0]  ptr_wd = '0;
   logic [11:0] eff_addr;
   logic [1:0]  addr_mode;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [3:0]  bank_s = '0;
   logic [11:0] ptr_s = '0;

   always #2.5 clk = ~clk;

   bank_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .instr(instr), .instr_valid(instr_valid),
      .ext_en(ext_en), .bank_we(bank_we), .bank_wd(bank_wd),
      .ptr_hi_we(ptr_hi_we), .ptr_lo_we(ptr_lo_we), .ptr_wd(ptr_wd),
      .eff_addr(eff_addr), .addr_mode(addr_mode)
   );

   function automatic logic [13:0] model(input logic [15:0] ins, input logic ex);
      logic [7:0] f = ins[7:0];
      if (ins[8])        return {2'd0, bank_s, f};
      else if (f >= 8'h60) return {2'd1, 4'hF, f};
      else if (ex)       return {2'd2, ptr_s + {4'h0, f}};
      else               return {2'd1, 4'h0, f};
   endfunction

   task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: mode/addr actual %0d/%03h expected %0d/%03h",
                  req, act[13:12], act[11:0], exp[13:12], exp[11:0]);
      end
   endtask

   task automatic wr_bank(input logic [3:0] v);
      @(negedge clk); bank_we = 1'b1; bank_wd = v;
      @(negedge clk); bank_we = 1'b0;
      bank_s = v;
   endtask

   task automatic wr_hi(input logic [7:0] v);
      @(negedge clk); ptr_hi_we = 1'b1; ptr_wd = v;
      @(negedge clk); ptr_hi_we = 1'b0;
      ptr_s[11:8] = v[3:0];
   endtask

   task automatic wr_lo(input logic [7:0] v);
      @(negedge clk); ptr_lo_we = 1'b1; ptr_wd = v;
      @(negedge clk); ptr_lo_we = 1'b0;
      ptr_s[7:0] = v;
   endtask

   task automatic decode(input string req, input logic [15:0] ins, input logic ex);
      logic [13:0] exp;
      @(negedge clk); instr = ins; ext_en = ex; instr_valid = 1'b1;
      exp = model(ins, ex);
      @(negedge clk); instr_valid = 1'b0;
      check(req, {addr_mode, eff_addr}, exp);
   endtask

   function automatic string req_of(input logic [15:0] ins, input logic ex);
      if (ins[8]) return "R1";
      if (ins[7:0] >= 8'h60) return "R2";
      return ex ? "R3" : "R4";
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [13:0] held;
      void'($urandom(32'h5EED_0B1D));
      repeat (3) @(negedge clk);
      check("R8 reset outputs", {addr_mode, eff_addr}, 14'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 after reset", {addr_mode, eff_addr}, 14'h0);
      decode("R8 ptr zero", 16'h0000, 1'b1);
      decode("R8 bank zero", 16'h01AB, 1'b0);

      wr_bank(4'h5);
      decode("R1 R6 bank 5", 16'h0134, 1'b0);
      decode("R5 upper bits", 16'hFF34, 1'b1);
      decode("R5 upper bits low", 16'hA25F, 1'b0);
      wr_bank(4'hF);
      decode("R1 bank F f=00", 16'h0100, 1'b1);
      decode("R2 f=60", 16'h0060, 1'b1);
      decode("R2 f=FF no ext", 16'h00FF, 1'b0);
      wr_hi(8'hFA);
      wr_lo(8'h10);
      decode("R3 R7 ptr A10 f=5F", 16'h005F, 1'b1);
      decode("R4 ext off f=5F", 16'h005F, 1'b0);
      wr_hi(8'h0F);
      wr_lo(8'hFF);
      decode("R3 wrap", 16'h005F, 1'b1);
      decode("R3 f=00", 16'h0000, 1'b1);

      held = {addr_mode, eff_addr};
      @(negedge clk); instr = 16'h0120; ext_en = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 hold", {addr_mode, eff_addr}, held);

      @(negedge clk); instr = 16'h0077; instr_valid = 1'b1;
      #1;
      check("R10 not before edge", {addr_mode, eff_addr}, held);
      @(negedge clk); instr_valid = 1'b0;
      check("R10 at edge", {addr_mode, eff_addr}, 14'h1F77);

      for (int i = 0; i < 400; i++) begin
         int op = $urandom_range(0, 7);
         if (op == 0) wr_bank(4'($urandom));
         else if (op == 1) wr_hi(8'($urandom));
         else if (op == 2) wr_lo(8'($urandom));
         else begin
            logic [15:0] ins = 16'($urandom);
            logic ex = 1'($urandom);
            decode({req_of(ins, ex), " R5 random"}, ins, ex);
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule